// File: doc/BRIEF.md
# DMA Channel Request Gate and FIFO Exception Monitor

This block sits between a peripheral's request line and the FIFO of one DMA channel. On every clock it compares the pending request with the FIFO's occupancy and free space. It then decides whether the request can be serviced now. In peripheral-to-memory transfers, a request waits until there is free room for the whole beat. In memory-to-peripheral transfers, it waits until enough items are stored. A request that has to wait is never dropped. The grant simply comes later, so no data is corrupted. Memory-to-memory transfers are not gated.

The block also raises two sticky exceptions, which software clears by writing one:
- The FIFO exception marks a request that arrived while there was not enough room or not enough data.
- The single-data exception marks a request that arrived, in single-data peripheral-to-memory operation, while the FIFO already held an item.

Neither exception changes the grant behaviour. Each exception feeds the shared interrupt only through its own enable.

Top module: `dma_fifo_guard`

## Requirements
- R1: The items needed per request follow `burst_sel_i`: 2'b00 needs 1, 2'b01 needs 4, 2'b10 needs 8, 2'b11 needs 16.
- R2: With `xfer_mode_i` = 2'b00 (peripheral-to-memory), a valid request is granted only when `fifo_free_i` is at least the needed item count. `grant_o` goes high on the clock edge after the cycle in which this holds.
- R3: With `xfer_mode_i` = 2'b01 (memory-to-peripheral), a valid request is granted only when `fifo_count_i` is at least the needed item count, with the same timing as R2.
- R4: With `xfer_mode_i` = 2'b10 (memory-to-memory) or 2'b11 (treated the same way), every valid request is granted whatever the FIFO levels are, and neither exception flag ever sets.
- R5: `grant_o` is high for exactly one cycle. A request seen while `grant_o` is high is not evaluated, so a request held high continuously is granted at most every other cycle.
- R6: A request that cannot be granted stays pending with no grant. It is granted on the edge after the cycle in which its space or data condition is met. There is never a grant without a request.
- R7: `fxe_flag_o` sets on the edge after the first cycle of a request that lacks space (mode 2'b00) or data (mode 2'b01). It sets at most once per request, even if the request stays stalled.
- R8: `sde_flag_o` sets on the edge after the first cycle of a request when `single_mode_i` = 1, mode is 2'b00, and `fifo_count_i` is nonzero. It does not set in any other mode or when the FIFO is empty.
- R9: Both flags are sticky. A high `clr_sde_i` or `clr_fxe_i` clears the matching flag on the next edge. When a set event and a clear happen in the same cycle, the set wins.
- R10: `irq_o` is high exactly when a flag is set and its enable (`sde_ie_i` or `fxe_ie_i`) is high. The enables have no effect on grants or flags.
- R11: During reset, `grant_o`, both flags and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_mode_i | input | 2 | Transfer direction: 00 per-to-mem, 01 mem-to-per, 10/11 mem-to-mem |
| single_mode_i | input | 1 | Single-data (FIFO bypass) operation enabled |
| burst_sel_i | input | 2 | Items per request: 1, 4, 8, 16 |
| fifo_count_i | input | CNT_W | Items currently stored in the FIFO |
| fifo_free_i | input | CNT_W | Free item slots in the FIFO |
| req_i | input | 1 | Peripheral request, held until granted |
| sde_ie_i | input | 1 | Interrupt enable for the single-data exception |
| fxe_ie_i | input | 1 | Interrupt enable for the FIFO exception |
| clr_sde_i | input | 1 | Write-one-to-clear strobe for the single-data flag |
| clr_fxe_i | input | 1 | Write-one-to-clear strobe for the FIFO flag |
| grant_o | output | 1 | One-cycle request grant |
| sde_flag_o | output | 1 | Sticky single-data exception flag |
| fxe_flag_o | output | 1 | Sticky FIFO overrun/underrun flag |
| irq_o | output | 1 | Interrupt |

## Verification
The bench builds the block with the default FIFO depth of 16, which gives a 5-bit level width. At this depth the 16-item burst can exactly fill or drain the FIFO, so every burst size can be driven both one item short of its need and exactly at it. A behavioural model tracks the pending request, the grant pulse and both flags, and its state is compared on every clock. The stimulus covers a request that is held through its own grant, a flag that is cleared while a stall goes on, and a clear that arrives in the same cycle as a new set event.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
  typedef enum logic [1:0] {
    MODE_P2M = 2'b00,
    MODE_M2P = 2'b01,
    MODE_M2M = 2'b10,
    MODE_RSV = 2'b11
  } xfer_mode_e;

  localparam int NEED_W = 5;
  localparam int FLAG_N = 2;
  localparam int FLAG_FXE = 0;
  localparam int FLAG_SDE = 1;

  function automatic logic [NEED_W-1:0] burst_items(input logic [1:0] sel);
    case (sel)
      2'b00:   burst_items = NEED_W'(1);
      2'b01:   burst_items = NEED_W'(4);
      2'b10:   burst_items = NEED_W'(8);
      default: burst_items = NEED_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/dfg_need_calc.sv
module dfg_need_calc
  import dfg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [1:0]       mode_i,
  input  logic [1:0]       burst_i,
  input  logic             single_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] free_i,
  output logic             room_ok_o,
  output logic             fifo_chk_o,
  output logic             sd_chk_o,
  output logic             not_empty_o
);
  localparam int CW = (CNT_W > NEED_W) ? CNT_W : NEED_W;

  logic [CW-1:0] need_w, count_w, free_w;
  xfer_mode_e    mode;

  assign mode    = xfer_mode_e'(mode_i);
  assign need_w  = CW'(burst_items(burst_i));
  assign count_w = CW'(count_i);
  assign free_w  = CW'(free_i);

  always_comb begin
    room_ok_o  = 1'b1;
    fifo_chk_o = 1'b0;
    case (mode)
      MODE_P2M: begin
        room_ok_o  = (free_w >= need_w);
        fifo_chk_o = 1'b1;
      end
      MODE_M2P: begin
        room_ok_o  = (count_w >= need_w);
        fifo_chk_o = 1'b1;
      end
      default: begin
        room_ok_o  = 1'b1;
        fifo_chk_o = 1'b0;
      end
    endcase
  end

  assign sd_chk_o    = single_i && (mode == MODE_P2M);
  assign not_empty_o = |count_i;
endmodule

// File: rtl/dfg_req_track.sv
module dfg_req_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic room_ok_i,
  output logic grant_o,
  output logic first_o
);
  logic grant_q, held_q, valid, grant_d;

  // request seen during its own grant cycle is the requester's release lag
  assign valid   = req_i & ~grant_q;
  assign grant_d = valid & room_ok_i;
  assign first_o = valid & ~held_q;
  assign grant_o = grant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      held_q  <= valid & ~room_ok_i;
    end
  end
endmodule

// File: rtl/dfg_flag_bank.sv
module dfg_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q[g] <= 1'b0;
      else if (set_i[g])   flag_q[g] <= 1'b1;
      else if (clr_i[g])   flag_q[g] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ie_i);
endmodule

// File: rtl/dma_fifo_guard.sv
module dma_fifo_guard
  import dfg_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       xfer_mode_i,
  input  logic             single_mode_i,
  input  logic [1:0]       burst_sel_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  input  logic [CNT_W-1:0] fifo_free_i,
  input  logic             req_i,
  input  logic             sde_ie_i,
  input  logic             fxe_ie_i,
  input  logic             clr_sde_i,
  input  logic             clr_fxe_i,
  output logic             grant_o,
  output logic             sde_flag_o,
  output logic             fxe_flag_o,
  output logic             irq_o
);
  logic              room_ok, fifo_chk, sd_chk, not_empty, first;
  logic [FLAG_N-1:0] set_v, clr_v, ie_v, flag_v;

  dfg_need_calc #(.CNT_W(CNT_W)) u_need (
    .mode_i      (xfer_mode_i),
    .burst_i     (burst_sel_i),
    .single_i    (single_mode_i),
    .count_i     (fifo_count_i),
    .free_i      (fifo_free_i),
    .room_ok_o   (room_ok),
    .fifo_chk_o  (fifo_chk),
    .sd_chk_o    (sd_chk),
    .not_empty_o (not_empty)
  );

  dfg_req_track u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .room_ok_i (room_ok),
    .grant_o   (grant_o),
    .first_o   (first)
  );

  assign set_v[FLAG_FXE] = first & fifo_chk & ~room_ok;
  assign set_v[FLAG_SDE] = first & sd_chk & not_empty;
  assign clr_v[FLAG_FXE] = clr_fxe_i;
  assign clr_v[FLAG_SDE] = clr_sde_i;
  assign ie_v[FLAG_FXE]  = fxe_ie_i;
  assign ie_v[FLAG_SDE]  = sde_ie_i;

  dfg_flag_bank #(.N(FLAG_N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .ie_i   (ie_v),
    .flag_o (flag_v),
    .irq_o  (irq_o)
  );

  assign fxe_flag_o = flag_v[FLAG_FXE];
  assign sde_flag_o = flag_v[FLAG_SDE];
endmodule

// File: rtl/dma_fifo_guard_chk.sv
module dma_fifo_guard_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       xfer_mode_i,
  input logic             single_mode_i,
  input logic [CNT_W-1:0] fifo_free_i,
  input logic             req_i,
  input logic             clr_sde_i,
  input logic             clr_fxe_i,
  input logic             grant_o,
  input logic             sde_flag_o,
  input logic             fxe_flag_o,
  input logic             irq_o
);
  // R5
  grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);

  // R6
  grant_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(req_i));

  // R2
  p2m_full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !grant_o && xfer_mode_i == 2'b00 && fifo_free_i == '0) |=> !grant_o);

  // R4
  m2m_no_fxe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_mode_i[1] |=> !$rose(fxe_flag_o));

  // R8
  sde_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(single_mode_i && xfer_mode_i == 2'b00) |=> !$rose(sde_flag_o));

  // R9
  fxe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fxe_flag_o && !clr_fxe_i) |=> fxe_flag_o);

  // R9
  sde_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sde_flag_o && !clr_sde_i) |=> sde_flag_o);

  // R10
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sde_flag_o || fxe_flag_o));
endmodule

bind dma_fifo_guard dma_fifo_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .xfer_mode_i   (xfer_mode_i),
  .single_mode_i (single_mode_i),
  .fifo_free_i   (fifo_free_i),
  .req_i         (req_i),
  .clr_sde_i     (clr_sde_i),
  .clr_fxe_i     (clr_fxe_i),
  .grant_o       (grant_o),
  .sde_flag_o    (sde_flag_o),
  .fxe_flag_o    (fxe_flag_o),
  .irq_o         (irq_o)
);

// File: tb/sim_dma_fifo_guard.sv
module sim_dma_fifo_guard;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode = 2'b00, burst = 2'b00;
  logic single = 1'b0, req = 1'b0, sde_ie = 1'b0, fxe_ie = 1'b0;
  logic clr_sde = 1'b0, clr_fxe = 1'b0;
  logic [CW-1:0] cnt = '0, fre = '0;
  logic grant, sde_f, fxe_f, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R11";

  // behavioural reference state
  bit m_grant = 0, m_pend = 0, m_sde = 0, m_fxe = 0;

  always #10 clk = ~clk;

  dma_fifo_guard #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .xfer_mode_i(mode), .single_mode_i(single),
    .burst_sel_i(burst), .fifo_count_i(cnt), .fifo_free_i(fre), .req_i(req),
    .sde_ie_i(sde_ie), .fxe_ie_i(fxe_ie), .clr_sde_i(clr_sde), .clr_fxe_i(clr_fxe),
    .grant_o(grant), .sde_flag_o(sde_f), .fxe_flag_o(fxe_f), .irq_o(irq));

  function automatic int need_of(input logic [1:0] b);
    int t[4] = '{1, 4, 8, 16};
    return t[b];
  endfunction

  task automatic chk(input string t, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d)", t, what, act, exp, cyc);
    end
  endtask

  task automatic model_tick();
    bit valid, ok, first, fx, sd;
    valid = req && !m_grant;
    case (mode)
      2'b00:   ok = int'(fre) >= need_of(burst);
      2'b01:   ok = int'(cnt) >= need_of(burst);
      default: ok = 1;
    endcase
    first = valid && !m_pend;
    fx = first && (mode < 2) && !ok;
    sd = first && single && (mode == 2'b00) && (cnt != 0);
    m_fxe = fx ? 1'b1 : (clr_fxe ? 1'b0 : m_fxe);
    m_sde = sd ? 1'b1 : (clr_sde ? 1'b0 : m_sde);
    m_pend = valid && !ok;
    m_grant = valid && ok;
  endtask

  task automatic compare();
    chk(tag, "grant_o", grant, m_grant);
    chk(tag, "fxe_flag_o", fxe_f, m_fxe);
    chk(tag, "sde_flag_o", sde_f, m_sde);
    chk(tag, "irq_o", irq, (m_sde && sde_ie) || (m_fxe && fxe_ie));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_tick();
      @(negedge clk);
      cyc++;
      compare();
    end
  endtask

  task automatic clear_all();
    clr_sde = 1; clr_fxe = 1; req = 0;
    run(1);
    clr_sde = 0; clr_fxe = 0;
    run(1);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", "grant_o", grant, 0);
    chk("R11", "fxe_flag_o", fxe_f, 0);
    chk("R11", "sde_flag_o", sde_f, 0);
    chk("R11", "irq_o", irq, 0);
    rst_ni = 1;
    run(2);

    // R1 R2: per-to-mem, every burst one short then exact
    for (int b = 0; b < 4; b++) begin
      tag = "R1 R2"; mode = 2'b00; burst = 2'(b); cnt = '0;
      fre = CW'(need_of(2'(b)) - 1); req = 1;
      run(3);
      chk("R2", "grant_o stalled", grant, 0);
      chk("R7", "fxe_flag_o", fxe_f, 1);
      fre = CW'(need_of(2'(b)));
      run(1);
      chk("R2", "grant_o at room", grant, 1);
      req = 0;
      run(1);
      clear_all();
    end

    // R1 R3: mem-to-per, data gating
    for (int b = 0; b < 4; b++) begin
      tag = "R1 R3"; mode = 2'b01; burst = 2'(b); fre = '0;
      cnt = CW'(need_of(2'(b)) - 1); req = 1;
      run(2);
      chk("R3", "grant_o stalled", grant, 0);
      cnt = CW'(need_of(2'(b)));
      run(1);
      chk("R3", "grant_o at data", grant, 1);
      req = 0;
      run(1);
      clear_all();
    end

    // R4: mem-to-mem and reserved code ignore levels
    for (int m = 2; m < 4; m++) begin
      tag = "R4"; mode = 2'(m); burst = 2'b11; cnt = '0; fre = '0; single = 1; req = 1;
      run(1);
      chk("R4", "grant_o", grant, 1);
      req = 0;
      run(1);
      chk("R4", "fxe_flag_o", fxe_f, 0);
    end
    single = 0;

    // R5: held request, room always present
    tag = "R5"; mode = 2'b00; burst = 2'b00; fre = CW'(DEPTH); req = 1;
    run(6);
    req = 0;
    run(1);

    // R6 R7: long stall, clear mid-stall, no re-set
    tag = "R6 R7"; mode = 2'b01; burst = 2'b10; cnt = CW'(3); req = 1;
    run(2);
    clr_fxe = 1;
    run(1);
    clr_fxe = 0;
    run(4);
    chk("R7", "fxe_flag_o once per request", fxe_f, 0);
    cnt = CW'(8);
    run(1);
    chk("R6", "grant_o after stall", grant, 1);
    req = 0;
    run(2);

    // R8: single-data exception scope
    tag = "R8"; mode = 2'b00; single = 1; burst = 2'b00; fre = CW'(10); cnt = CW'(2); req = 1;
    run(1);
    chk("R8", "sde_flag_o set", sde_f, 1);
    req = 0;
    clear_all();
    cnt = '0; req = 1;
    run(1);
    chk("R8", "sde_flag_o empty fifo", sde_f, 0);
    req = 0; run(1);
    mode = 2'b01; cnt = CW'(5); req = 1;
    run(1);
    chk("R8", "sde_flag_o m2p", sde_f, 0);
    req = 0; run(1);

    // R9: set wins over a simultaneous clear
    tag = "R9"; mode = 2'b00; cnt = CW'(1); fre = CW'(10); req = 1;
    run(1);
    req = 0; run(1);
    req = 1; clr_sde = 1;
    run(1);
    chk("R9", "sde_flag_o set beats clear", sde_f, 1);
    req = 0; clr_sde = 0;
    run(3);
    chk("R9", "sde_flag_o sticky", sde_f, 1);

    // R10: enables steer irq only
    tag = "R10"; fre = '0; single = 0; req = 1;
    run(2);
    sde_ie = 1; run(1);
    chk("R10", "irq_o via sde", irq, 1);
    sde_ie = 0; fxe_ie = 1; run(1);
    chk("R10", "irq_o via fxe", irq, 1);
    fxe_ie = 0; run(1);
    chk("R10", "irq_o masked", irq, 0);
    req = 0;
    clear_all();
    fxe_ie = 1; sde_ie = 1; run(1);
    chk("R10", "irq_o no flags", irq, 0);

    finish_up();
  end
endmodule